// File: doc/BRIEF.md
# Product-Term Steering Network

This block sits between the AND plane of a programmable logic block and its macrocells. It receives a flat vector of product-term results, grouped into fixed clusters of five, and forms one sum-of-products bit per macrocell. Static configuration bits decide how clusters are combined. A chain of neighbouring clusters can be merged into one wide sum at the lowest cluster of the chain, which is called the head. Any single output can instead take a fast path that ORs only its own cluster.

The network is purely combinational. It has no clock and no storage, so every output settles in the same cycle as its inputs. The AND plane, the macrocell registers and the loading of configuration bits are outside this block. A separate group of five control product terms goes past the steering logic untouched and is presented as the block's set, reset, clock, clock-enable and output-enable terms.

Each output works in one of three modes. In SHARE mode, the cluster is a head and sums its chain. In LENT mode, the cluster has been joined to the group below it and drives 0. In BYPASS mode, the output takes its own cluster's OR. BYPASS is selected when the output's bypass bit is set. Otherwise the mode is LENT when the cluster's link bit is set, and SHARE when it is not.

Top module: `ptsa_array`

## Requirements
- R1: Cluster c holds the term bits `pt_in[5c+4:5c]`. When `cfg_bypass[c]` is 1, `sum_out[c]` equals the OR of those five bits.
- R2: For a head cluster h with bypass clear, `sum_out[h]` is the OR of cluster h and of every following cluster h+1, h+2, … whose link bit is 1, up to the first cluster whose link bit is 0.
- R3: `cfg_link[c]` = 1 for c > 0 joins cluster c to the group of cluster c-1. `cfg_link[0]` has no effect, and cluster 0 is always a head.
- R4: An output whose cluster is lent (`cfg_link[c]` = 1, c > 0) and whose bypass bit is clear drives 0.
- R5: A group holds at most 7 clusters, which is 35 terms. Linked clusters beyond the seventh in a chain contribute to no shared output.
- R6: Setting bypass on a head makes its output ignore the clusters linked to it.
- R7: A lent cluster with bypass set drives its own cluster's OR and still contributes to its head's sum.
- R8: Control terms go straight to the control outputs, whatever the configuration. Bit 0 drives `ctl_set`, bit 1 `ctl_reset`, bit 2 `ctl_clk`, bit 3 `ctl_ce` and bit 4 `ctl_oe`.
- R9: The outputs follow input changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | 160 | Product-term results, five per cluster |
| ctl_pt_in | input | 5 | Shared control product terms |
| cfg_bypass | input | 32 | Per-output fast-path select |
| cfg_link | input | 32 | Per-cluster join-to-lower-neighbour bits |
| sum_out | output | 32 | One sum-of-products bit per macrocell |
| ctl_set | output | 1 | Set term |
| ctl_reset | output | 1 | Reset term |
| ctl_clk | output | 1 | Clock term |
| ctl_ce | output | 1 | Clock-enable term |
| ctl_oe | output | 1 | Output-enable term |

## Verification
The assertions are evaluated on every input change. They check four things at the ports: that bypassed outputs match their own cluster, that lent outputs stay at 0, that a head is never below its own cluster, and that a shared output is set only when some cluster inside its seven-cluster window is set. The exact membership of a group cannot be seen by these local checks. That covers the clipping of long chains, the ignored link bit of cluster 0, and a bypassed cluster that is still lent to its head. Only the bench's directed cases and its randomised comparison against a reference model can show those behaviours.

// File: rtl/ptsa_pkg.sv
`timescale 1ns/1ps
package ptsa_pkg;
    typedef enum logic [1:0] {
        MODE_SHARE  = 2'd0,
        MODE_LENT   = 2'd1,
        MODE_BYPASS = 2'd2
    } out_mode_e;
endpackage

// File: rtl/ptsa_cluster_or.sv
`timescale 1ns/1ps
module ptsa_cluster_or #(
    parameter int N_CLUST = 32,
    parameter int TERMS   = 5
) (
    input  logic [N_CLUST*TERMS-1:0] pt_in,
    output logic [N_CLUST-1:0]       cl_sum
);
    for (genvar gc = 0; gc < N_CLUST; gc++) begin : g_cl
        assign cl_sum[gc] = |pt_in[gc*TERMS +: TERMS];
    end
endmodule

// File: rtl/ptsa_chain_depth.sv
`timescale 1ns/1ps
module ptsa_chain_depth #(
    parameter int N_CLUST  = 32,
    parameter int MAX_SPAN = 7,
    localparam int DW      = $clog2(MAX_SPAN + 1)
) (
    input  logic [N_CLUST-1:0]         cfg_link,
    output logic [N_CLUST-1:0][DW-1:0] depth,
    output logic [N_CLUST-1:0]         lent
);
    // depth = position inside a chain; MAX_SPAN marks a clipped cluster
    always_comb begin
        depth[0] = '0;
        lent[0]  = 1'b0;
        for (int i = 1; i < N_CLUST; i++) begin
            lent[i] = cfg_link[i];
            if (!cfg_link[i])
                depth[i] = '0;
            else if (depth[i-1] == DW'(MAX_SPAN))
                depth[i] = DW'(MAX_SPAN);
            else
                depth[i] = depth[i-1] + DW'(1);
        end
    end
endmodule

// File: rtl/ptsa_steer.sv
`timescale 1ns/1ps
module ptsa_steer
    import ptsa_pkg::*;
#(
    parameter int N_CLUST  = 32,
    parameter int MAX_SPAN = 7,
    localparam int DW      = $clog2(MAX_SPAN + 1)
) (
    input  logic [N_CLUST-1:0]         cl_sum,
    input  logic [N_CLUST-1:0][DW-1:0] depth,
    input  logic [N_CLUST-1:0]         lent,
    input  logic [N_CLUST-1:0]         cfg_bypass,
    output logic [N_CLUST-1:0]         sum_out
);
    for (genvar gi = 0; gi < N_CLUST; gi++) begin : g_out
        logic      shared;
        out_mode_e mode;

        always_comb begin
            shared = cl_sum[gi];
            for (int j = 1; j < MAX_SPAN; j++) begin
                if (gi + j < N_CLUST) begin
                    if (depth[(gi+j) % N_CLUST] == DW'(j))
                        shared = shared | cl_sum[(gi+j) % N_CLUST];
                end
            end
        end

        always_comb begin
            if (cfg_bypass[gi])   mode = MODE_BYPASS;
            else if (lent[gi])    mode = MODE_LENT;
            else                  mode = MODE_SHARE;
        end

        always_comb begin
            unique case (mode)
                MODE_BYPASS: sum_out[gi] = cl_sum[gi];
                MODE_LENT:   sum_out[gi] = 1'b0;
                MODE_SHARE:  sum_out[gi] = shared;
                default:     sum_out[gi] = 1'b0;
            endcase
        end

        // a shared sum may only come from its seven-cluster window
        always_comb begin
            logic any_win;
            any_win = 1'b0;
            for (int j = 0; j < MAX_SPAN; j++)
                if (gi + j < N_CLUST) any_win = any_win | cl_sum[(gi+j) % N_CLUST];
            p_window_bound_r5: assert (!(sum_out[gi] && !cfg_bypass[gi]) || any_win)
                else $error("R5 window bound violated at %0d", gi);
        end
    end
endmodule

// File: rtl/ptsa_array.sv
`timescale 1ns/1ps
module ptsa_array #(
    parameter int N_CLUST  = 32,
    parameter int TERMS    = 5,
    parameter int MAX_SPAN = 7,
    localparam int NPT     = N_CLUST * TERMS,
    localparam int DW      = $clog2(MAX_SPAN + 1)
) (
    input  logic [NPT-1:0]     pt_in,
    input  logic [4:0]         ctl_pt_in,
    input  logic [N_CLUST-1:0] cfg_bypass,
    input  logic [N_CLUST-1:0] cfg_link,
    output logic [N_CLUST-1:0] sum_out,
    output logic               ctl_set,
    output logic               ctl_reset,
    output logic               ctl_clk,
    output logic               ctl_ce,
    output logic               ctl_oe
);
    logic [N_CLUST-1:0]         cl_sum;
    logic [N_CLUST-1:0][DW-1:0] depth;
    logic [N_CLUST-1:0]         lent;

    ptsa_cluster_or #(.N_CLUST(N_CLUST), .TERMS(TERMS)) u_cl (
        .pt_in (pt_in),
        .cl_sum(cl_sum)
    );

    ptsa_chain_depth #(.N_CLUST(N_CLUST), .MAX_SPAN(MAX_SPAN)) u_chain (
        .cfg_link(cfg_link),
        .depth   (depth),
        .lent    (lent)
    );

    ptsa_steer #(.N_CLUST(N_CLUST), .MAX_SPAN(MAX_SPAN)) u_steer (
        .cl_sum    (cl_sum),
        .depth     (depth),
        .lent      (lent),
        .cfg_bypass(cfg_bypass),
        .sum_out   (sum_out)
    );

    // control terms skip the steering network
    assign ctl_set   = ctl_pt_in[0];
    assign ctl_reset = ctl_pt_in[1];
    assign ctl_clk   = ctl_pt_in[2];
    assign ctl_ce    = ctl_pt_in[3];
    assign ctl_oe    = ctl_pt_in[4];

    always_comb begin
        for (int i = 0; i < N_CLUST; i++) begin
            p_bypass_own_r1: assert (!cfg_bypass[i] || sum_out[i] == |pt_in[i*TERMS +: TERMS])
                else $error("R1 bypass output %0d mismatch", i);
            p_lent_zero_r4: assert (!(i > 0 && cfg_link[i] && !cfg_bypass[i]) || !sum_out[i])
                else $error("R4 lent output %0d not zero", i);
            p_head_covers_own_r2: assert (!((i == 0 || !cfg_link[i]) && !cfg_bypass[i]
                                            && |pt_in[i*TERMS +: TERMS]) || sum_out[i])
                else $error("R2 head output %0d lost own cluster", i);
        end
    end
endmodule

// File: tb/ptsa_array_bench.sv
`timescale 1ns/1ps
module ptsa_array_bench;
    localparam int N = 32;
    localparam int T = 5;
    localparam int M = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [N*T-1:0] pt_in;
    logic [4:0]     ctl_pt_in;
    logic [N-1:0]   cfg_bypass, cfg_link, sum_out;
    logic           ctl_set, ctl_reset, ctl_clk, ctl_ce, ctl_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ptsa_array u_ptsa_array (
        .pt_in(pt_in), .ctl_pt_in(ctl_pt_in),
        .cfg_bypass(cfg_bypass), .cfg_link(cfg_link),
        .sum_out(sum_out),
        .ctl_set(ctl_set), .ctl_reset(ctl_reset), .ctl_clk(ctl_clk),
        .ctl_ce(ctl_ce), .ctl_oe(ctl_oe)
    );

    function automatic logic clus(logic [N*T-1:0] p, int c);
        return |p[c*T +: T];
    endfunction

    function automatic logic [N-1:0] model(logic [N*T-1:0] p, logic [N-1:0] byp, logic [N-1:0] lnk);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (byp[i]) r[i] = clus(p, i);
            else if (i > 0 && lnk[i]) r[i] = 1'b0;
            else begin
                int j = i + 1;
                int n = 1;
                r[i] = clus(p, i);
                while (j < N && lnk[j] && n < M) begin
                    r[i] = r[i] | clus(p, j);
                    j++;
                    n++;
                end
            end
        end
        return r;
    endfunction

    task automatic drive(logic [N*T-1:0] p, logic [4:0] c, logic [N-1:0] byp, logic [N-1:0] lnk);
        @(negedge clk);
        pt_in = p; ctl_pt_in = c; cfg_bypass = byp; cfg_link = lnk;
        #1;
    endtask

    task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*T-1:0] one_term(int c, int k);
        logic [N*T-1:0] p = '0;
        p[c*T + k] = 1'b1;
        return p;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*T-1:0] p;
        logic [N-1:0]   byp, lnk, exp;
        void'($urandom(32'h5eed_1234));
        pt_in = '0; ctl_pt_in = '0; cfg_bypass = '0; cfg_link = '0;

        // idle state: nothing asserted
        drive('0, 5'd0, '0, '0);
        check_vec("R2 idle", sum_out, '0);
        check_vec("R8 idle ctl", {27'd0, ctl_oe, ctl_ce, ctl_clk, ctl_reset, ctl_set}, '0);

        // R1: every output bypassed
        for (int t = 0; t < 4; t++) begin
            p = {$urandom, $urandom, $urandom, $urandom, $urandom};
            lnk = $urandom;
            drive(p, 5'd0, '1, lnk);
            for (int i = 0; i < N; i++) exp[i] = clus(p, i);
            check_vec("R1 bypass all", sum_out, exp);
        end

        // R3: link bit of cluster 0 ignored
        drive(one_term(0, 3), 5'd0, '0, 32'h1);
        check_vec("R3 link0", sum_out, 32'h1);

        // R2 / R4: chain 0..2, term in cluster 2
        drive(one_term(2, 4), 5'd0, '0, 32'h6);
        check_vec("R2 R4 chain", sum_out, 32'h1);

        // R2: two groups side by side
        drive(one_term(5, 0) | one_term(9, 1), 5'd0, '0, 32'h0000_0220);
        check_vec("R2 groups", sum_out, 32'h0000_0110);

        // R5: full chain, seventh cluster reaches head, eighth does not
        drive(one_term(6, 2), 5'd0, '0, 32'hFFFF_FFFE);
        check_vec("R5 seventh", sum_out, 32'h1);
        drive(one_term(7, 2), 5'd0, '0, 32'hFFFF_FFFE);
        check_vec("R5 clipped", sum_out, 32'h0);

        // R6: bypassed head ignores follower
        drive(one_term(1, 0), 5'd0, 32'h1, 32'h2);
        check_vec("R6 head bypass", sum_out, 32'h0);

        // R7: bypassed lent cluster still feeds head
        drive(one_term(1, 0), 5'd0, 32'h2, 32'h2);
        check_vec("R7 lent bypass", sum_out, 32'h3);

        // R8: control terms under random configs
        for (int t = 0; t < 6; t++) begin
            logic [4:0] c = 5'($urandom);
            drive({$urandom, $urandom, $urandom, $urandom, $urandom}, c, $urandom, $urandom);
            check_vec("R8 ctl", {27'd0, ctl_oe, ctl_ce, ctl_clk, ctl_reset, ctl_set}, {27'd0, c});
        end

        // R9: input change without clock edge
        @(posedge clk);
        #0.5;
        pt_in = one_term(3, 1); cfg_bypass = '0; cfg_link = 32'h10;
        #0.5;
        check_vec("R9 comb", sum_out, 32'h8);

        // randomised comparison against reference
        for (int t = 0; t < 400; t++) begin
            p = '0;
            for (int i = 0; i < N; i++)
                if (($urandom % 3) == 0) p[i*T + ($urandom % T)] = 1'b1;
            byp = $urandom & $urandom;
            lnk = (t % 5 == 0) ? ~($urandom & $urandom & $urandom) : $urandom;
            drive(p, 5'($urandom), byp, lnk);
            check_vec("R2 R5 random", sum_out, model(p, byp, lnk));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule